// File: doc/BRIEF.md
# Initialization Address Register Unit with Pointer Extension

This unit sits beside the bus-master engine of a network controller. It keeps the 32-bit base address of the initialization block in two 16-bit halves. Software reaches each half at a primary index and at a second alias index. The address halves can be read or written only while the controller is halted or suspended. They keep their contents through every kind of reset, so software can program them once before a restart.

The unit also builds full bus-master addresses. A combinational port takes a pointer and a kind tag and returns the 32-bit address. When the structure-size mode selects 16-bit software structures, descriptor and buffer pointers carry only 24 useful bits, and the top byte of the stored base address is placed above them. When the mode selects 32-bit structures, those pointers pass through unchanged. A one-cycle load strobe copies the formed address into a held register, so the value read back later is the complete 32-bit address. A separate register carries a babble interrupt mask bit, which can be accessed at any time.

Top module: `initaddr_csr`

## Requirements
- R1: A write to the low address register at index 1, while access is open, stores write bits 15:0 with bits 1:0 forced to zero. A read returns the stored value in bits 15:0 and zero in bits 31:16.
- R2: A write to the high address register at index 2, while access is open, stores write bits 15:0. Bits 15:8 are address bits 31:24 and bits 7:0 are address bits 23:16. A read returns zero in bits 31:16.
- R3: Access is open while halt_st or susp_st is 1. When both are 0, writes to indices 1, 2, 16 and 17 change nothing, and reads of those indices return zero.
- R4: Index 16 is an alias of index 1 and index 17 is an alias of index 2. Both indices of a pair write and read the same storage.
- R5: The address registers keep their contents through rst_n low, through a sw_rst pulse and through changes of halt_st.
- R6: With ptr_kind 0 (initialization), ptr_addr equals {high register, low register} in either mode. ptr_in is ignored.
- R7: With wide_ptr 1 and ptr_kind 1 (descriptor) or 2 (buffer), ptr_addr equals ptr_in.
- R8: With wide_ptr 0 and ptr_kind 1 or 2, ptr_addr is {high register bits 15:8, ptr_in bits 23:0}.
- R9: When ptr_load is 1 at a clock edge and ptr_kind is 1 or 2, held_addr shows that cycle's ptr_addr after the edge. With any other kind, held_addr keeps its value.
- R10: With ptr_kind 3 (reserved), ptr_addr equals ptr_in in either mode.
- R11: The mask register at index 3 holds the babble mask at bit 14. It can be written and read whatever the run state. It is cleared by rst_n low or by a sw_rst pulse, and it does not change when halt_st changes.
- R12: babble_irq is babble_evt while the mask is 0, and 0 while the mask is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| sw_rst | input | 1 | Software reset pulse, synchronous |
| halt_st | input | 1 | Controller is stopped |
| susp_st | input | 1 | Controller is suspended |
| wide_ptr | input | 1 | 1 = 32-bit software structures, 0 = 16-bit structures |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 7 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_idx (combinational) |
| ptr_in | input | 32 | Pointer to extend |
| ptr_kind | input | 2 | 0 init, 1 descriptor, 2 buffer, 3 reserved |
| ptr_load | input | 1 | Copy the formed address into held_addr |
| ptr_addr | output | 32 | Formed bus-master address |
| held_addr | output | 32 | Last loaded descriptor or buffer address |
| babble_evt | input | 1 | Babble event from the receive logic |
| babble_irq | output | 1 | Babble interrupt request after masking |

## Verification
The assertions assume that reg_idx, reg_we, ptr_kind and ptr_load stay steady for a whole cycle, and that sw_rst is a synchronous pulse. They also assume the address halves are programmed before the formed address is relied on, because those halves have no reset value. The stimulus changes every input just after a rising edge and writes both address halves while halted before it forms any address. Stores that must be ignored happen only after valid contents exist, so the check against the previous value compares known data.

// File: rtl/iac_pkg.sv
package iac_pkg;
   typedef enum logic [1:0] {
      PK_INIT = 2'd0,
      PK_DESC = 2'd1,
      PK_BUF  = 2'd2,
      PK_RSVD = 2'd3
   } ptr_kind_e;
endpackage

// File: rtl/iac_addr_regs.sv
module iac_addr_regs #(
   parameter int HALF_W     = 16,
   parameter int REG_W      = 32,
   parameter int IDX_W      = 7,
   parameter int ALIGN_BITS = 2,
   parameter int IDX_LO     = 1,
   parameter int IDX_HI     = 2,
   parameter int IDX_LO_ALT = 16,
   parameter int IDX_HI_ALT = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_ok,
   input  logic              reg_we,
   input  logic [IDX_W-1:0]  reg_idx,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  rd_data,
   output logic [HALF_W-1:0] lo_q,
   output logic [HALF_W-1:0] hi_q
);
   localparam int PAD_W = REG_W - HALF_W;

   logic              hit_lo, hit_hi;
   logic [HALF_W-1:0] lo_in;

   if (PAD_W < 1)
      $error("REG_W must exceed HALF_W");
   if (ALIGN_BITS < 0 || ALIGN_BITS >= HALF_W)
      $error("ALIGN_BITS out of range");

   assign hit_lo = (reg_idx == IDX_W'(IDX_LO)) || (reg_idx == IDX_W'(IDX_LO_ALT));
   assign hit_hi = (reg_idx == IDX_W'(IDX_HI)) || (reg_idx == IDX_W'(IDX_HI_ALT));

   if (ALIGN_BITS > 0) begin : g_align
      assign lo_in = {reg_wdata[HALF_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
   end else begin : g_noalign
      assign lo_in = reg_wdata[HALF_W-1:0];
   end

   // no reset on purpose: contents survive every reset
   always_ff @(posedge clk) begin
      if (reg_we && acc_ok && hit_lo) lo_q <= lo_in;
      if (reg_we && acc_ok && hit_hi) hi_q <= reg_wdata[HALF_W-1:0];
   end

   always_comb begin
      rd_data = '0;
      if (acc_ok && hit_lo)      rd_data = {{PAD_W{1'b0}}, lo_q};
      else if (acc_ok && hit_hi) rd_data = {{PAD_W{1'b0}}, hi_q};
   end

   // R3
   lo_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && !acc_ok && hit_lo) |=> (lo_q == $past(lo_q)));
   // R3
   hi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && !acc_ok && hit_hi) |=> (hi_q == $past(hi_q)));
   // R1
   lo_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && acc_ok && hit_lo) |=> (lo_q[1:0] == 2'b00));
   // R3
   rd_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_ok && (hit_lo || hit_hi)) |-> (rd_data == '0));
endmodule

// File: rtl/iac_addr_form.sv
module iac_addr_form
   import iac_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int EXT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wide_mode,
   input  logic [ADDR_W-1:0] init_addr,
   input  logic [ADDR_W-1:0] ptr_in,
   input  ptr_kind_e         kind,
   input  logic              load,
   output logic [ADDR_W-1:0] form_addr,
   output logic [ADDR_W-1:0] held_q
);
   localparam int LOW_W = ADDR_W - EXT_W;

   logic [EXT_W-1:0]  ext_byte;
   logic [ADDR_W-1:0] narrow_addr;
   logic              is_data_ptr;

   if (EXT_W < 1 || EXT_W >= ADDR_W)
      $error("EXT_W out of range");

   assign ext_byte    = init_addr[ADDR_W-1:LOW_W];
   assign narrow_addr = {ext_byte, ptr_in[LOW_W-1:0]};
   assign is_data_ptr = (kind == PK_DESC) || (kind == PK_BUF);

   always_comb begin
      unique case (kind)
         PK_INIT:         form_addr = init_addr;
         PK_DESC, PK_BUF: form_addr = wide_mode ? ptr_in : narrow_addr;
         default:         form_addr = ptr_in;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 held_q <= '0;
      else if (load && is_data_ptr) held_q <= form_addr;
   end

   // R6
   init_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == PK_INIT) |-> (form_addr == init_addr));
   // R8
   narrow_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wide_mode && is_data_ptr) |->
      (form_addr[ADDR_W-1:LOW_W] == init_addr[ADDR_W-1:LOW_W]
       && form_addr[LOW_W-1:0] == ptr_in[LOW_W-1:0]));
   // R9
   held_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && is_data_ptr) |=> (held_q == $past(form_addr)));
   // R9
   held_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && is_data_ptr) |=> $stable(held_q));
endmodule

// File: rtl/iac_babble_mask.sv
module iac_babble_mask #(
   parameter int REG_W    = 32,
   parameter int IDX_W    = 7,
   parameter int IDX_IMR  = 3,
   parameter int MASK_BIT = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_rst,
   input  logic             reg_we,
   input  logic [IDX_W-1:0] reg_idx,
   input  logic [REG_W-1:0] reg_wdata,
   input  logic             babble_evt,
   output logic [REG_W-1:0] rd_data,
   output logic             irq
);
   logic hit, mask_q;

   if (MASK_BIT < 0 || MASK_BIT >= REG_W)
      $error("MASK_BIT out of range");

   assign hit = (reg_idx == IDX_W'(IDX_IMR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             mask_q <= 1'b0;
      else if (sw_rst)        mask_q <= 1'b0;
      else if (reg_we && hit) mask_q <= reg_wdata[MASK_BIT];
   end

   always_comb begin
      rd_data = '0;
      if (hit) rd_data[MASK_BIT] = mask_q;
   end

   assign irq = babble_evt && !mask_q;

   // R12
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mask_q |-> !irq);
   // R11
   swrst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_rst |=> !mask_q);
   // R11
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_rst && !(reg_we && hit)) |=> $stable(mask_q));
endmodule

// File: rtl/initaddr_csr.sv
module initaddr_csr
   import iac_pkg::*;
#(
   parameter int REG_W      = 32,
   parameter int HALF_W     = 16,
   parameter int EXT_W      = 8,
   parameter int IDX_W      = 7,
   parameter int ALIGN_BITS = 2,
   parameter int MASK_BIT   = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_rst,
   input  logic             halt_st,
   input  logic             susp_st,
   input  logic             wide_ptr,
   input  logic             reg_we,
   input  logic [IDX_W-1:0] reg_idx,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic [REG_W-1:0] ptr_in,
   input  logic [1:0]       ptr_kind,
   input  logic             ptr_load,
   output logic [REG_W-1:0] ptr_addr,
   output logic [REG_W-1:0] held_addr,
   input  logic             babble_evt,
   output logic             babble_irq
);
   localparam int ADDR_W = 2 * HALF_W;

   if (ADDR_W != REG_W)
      $error("REG_W must be twice HALF_W");

   logic              acc_ok;
   logic [HALF_W-1:0] lo_q, hi_q;
   logic [REG_W-1:0]  rd_addr, rd_mask;

   assign acc_ok    = halt_st || susp_st;
   assign reg_rdata = rd_addr | rd_mask;

   iac_addr_regs #(
      .HALF_W(HALF_W), .REG_W(REG_W), .IDX_W(IDX_W), .ALIGN_BITS(ALIGN_BITS),
      .IDX_LO(1), .IDX_HI(2), .IDX_LO_ALT(16), .IDX_HI_ALT(17)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .acc_ok(acc_ok), .reg_we(reg_we),
      .reg_idx(reg_idx), .reg_wdata(reg_wdata), .rd_data(rd_addr),
      .lo_q(lo_q), .hi_q(hi_q)
   );

   iac_addr_form #(.ADDR_W(ADDR_W), .EXT_W(EXT_W)) u_form (
      .clk(clk), .rst_n(rst_n), .wide_mode(wide_ptr),
      .init_addr({hi_q, lo_q}), .ptr_in(ptr_in),
      .kind(ptr_kind_e'(ptr_kind)), .load(ptr_load),
      .form_addr(ptr_addr), .held_q(held_addr)
   );

   iac_babble_mask #(
      .REG_W(REG_W), .IDX_W(IDX_W), .IDX_IMR(3), .MASK_BIT(MASK_BIT)
   ) u_mask (
      .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .reg_we(reg_we),
      .reg_idx(reg_idx), .reg_wdata(reg_wdata), .babble_evt(babble_evt),
      .rd_data(rd_mask), .irq(babble_irq)
   );
endmodule

// File: tb/tb_initaddr_csr.sv
`timescale 1ns/100ps
module tb_initaddr_csr;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0, sw_rst = 1'b0, halt_st = 1'b1, susp_st = 1'b0;
   logic        wide_ptr = 1'b0, reg_we = 1'b0, ptr_load = 1'b0, babble_evt = 1'b0;
   logic [6:0]  reg_idx = '0;
   logic [31:0] reg_wdata = '0, ptr_in = '0;
   logic [1:0]  ptr_kind = 2'd0;
   logic [31:0] reg_rdata, ptr_addr, held_addr;
   logic        babble_irq;

   int n_run = 0, n_fail = 0;
   bit finished = 1'b0;

   typedef struct {
      int          sel;   // 0 rdata, 1 ptr_addr, 2 held_addr, 3 irq
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t sb[$];

   always #2.5 clk = ~clk;

   initaddr_csr dut (
      .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .halt_st(halt_st),
      .susp_st(susp_st), .wide_ptr(wide_ptr), .reg_we(reg_we),
      .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ptr_in(ptr_in), .ptr_kind(ptr_kind), .ptr_load(ptr_load),
      .ptr_addr(ptr_addr), .held_addr(held_addr),
      .babble_evt(babble_evt), .babble_irq(babble_irq)
   );

   // monitor: compare queued expectations away from the rising edge
   always @(negedge clk) begin
      while (sb.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it = sb.pop_front();
         case (it.sel)
            0: act = reg_rdata;
            1: act = ptr_addr;
            2: act = held_addr;
            default: act = {31'd0, babble_irq};
         endcase
         n_run++;
         if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", it.tag, act, it.exp);
         end
      end
   end

   task automatic cyc();
      @(posedge clk); #1;
   endtask

   task automatic wr(input logic [6:0] idx, input logic [31:0] d);
      reg_idx = idx; reg_wdata = d; reg_we = 1'b1;
      cyc();
      reg_we = 1'b0;
   endtask

   task automatic expect_val(input int sel, input logic [31:0] e, input string tag);
      item_t it;
      it.sel = sel; it.exp = e; it.tag = tag;
      sb.push_back(it);
      cyc();
   endtask

   task automatic rd(input logic [6:0] idx, input logic [31:0] e, input string tag);
      reg_idx = idx;
      expect_val(0, e, tag);
   endtask

   task automatic form(input logic [1:0] k, input logic [31:0] p, input logic [31:0] e,
                       input string tag);
      ptr_kind = k; ptr_in = p;
      expect_val(1, e, tag);
   endtask

   initial begin
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();
      rd(7'd3, 32'h0, "R11 mask clear after reset");
      babble_evt = 1'b1;
      expect_val(3, 32'h1, "R12 unmasked babble raises irq");
      babble_evt = 1'b0;
      expect_val(3, 32'h0, "R12 no babble no irq");

      wr(7'd1, 32'hFFFF_1237);
      rd(7'd1, 32'h0000_1234, "R1 low reg aligned, upper zero");
      rd(7'd16, 32'h0000_1234, "R4 alias 16 reads low reg");
      wr(7'd17, 32'hABCD_5A3C);
      rd(7'd2, 32'h0000_5A3C, "R2 high reg via alias 17 write");
      rd(7'd17, 32'h0000_5A3C, "R4 alias 17 reads high reg");

      wide_ptr = 1'b0;
      form(2'd0, 32'hFFFF_FFFF, 32'h5A3C_1234, "R6 init addr narrow mode");
      wide_ptr = 1'b1;
      form(2'd0, 32'h0, 32'h5A3C_1234, "R6 init addr wide mode");
      form(2'd1, 32'h1122_3344, 32'h1122_3344, "R7 wide descriptor passthrough");
      form(2'd2, 32'hC0FF_EE00, 32'hC0FF_EE00, "R7 wide buffer passthrough");
      wide_ptr = 1'b0;
      form(2'd1, 32'h1122_3344, 32'h5A22_3344, "R8 narrow descriptor extended");
      form(2'd2, 32'h00FF_FFFF, 32'h5AFF_FFFF, "R8 narrow buffer extended");
      form(2'd3, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R10 reserved kind passthrough");

      ptr_kind = 2'd2; ptr_in = 32'h7700_0010; ptr_load = 1'b1;
      cyc();
      ptr_load = 1'b0;
      expect_val(2, 32'h5A00_0010, "R9 held loads formed buffer addr");
      ptr_kind = 2'd0; ptr_load = 1'b1;
      cyc();
      ptr_load = 1'b0;
      expect_val(2, 32'h5A00_0010, "R9 init kind does not load held");

      halt_st = 1'b0; susp_st = 1'b1;
      wr(7'd2, 32'h0000_6B00);
      rd(7'd2, 32'h0000_6B00, "R3 write allowed while suspended");
      susp_st = 1'b0;
      wr(7'd1, 32'h0000_9998);
      wr(7'd17, 32'h0000_0101);
      rd(7'd1, 32'h0, "R3 closed read returns zero");
      halt_st = 1'b1;
      rd(7'd1, 32'h0000_1234, "R3 closed write to low ignored");
      rd(7'd2, 32'h0000_6B00, "R3 closed write to alias 17 ignored");

      halt_st = 1'b0;
      wr(7'd3, 32'h0000_4000);
      rd(7'd3, 32'h0000_4000, "R11 mask written while running");
      babble_evt = 1'b1;
      expect_val(3, 32'h0, "R12 masked babble quiet");
      halt_st = 1'b1; cyc(); halt_st = 1'b0;
      rd(7'd3, 32'h0000_4000, "R11 mask unaffected by halt");
      sw_rst = 1'b1; cyc(); sw_rst = 1'b0;
      rd(7'd3, 32'h0, "R11 sw reset clears mask");
      expect_val(3, 32'h1, "R12 irq back after unmask");
      babble_evt = 1'b0;
      wr(7'd3, 32'h0000_4000);
      rst_n = 1'b0; cyc(); rst_n = 1'b1;
      rd(7'd3, 32'h0, "R11 hw reset clears mask");

      halt_st = 1'b1;
      rd(7'd16, 32'h0000_1234, "R5 low reg survives resets and halt");
      rd(7'd2, 32'h0000_6B00, "R5 high reg survives resets and halt");
      wide_ptr = 1'b0;
      form(2'd1, 32'h0012_3456, 32'h6B12_3456, "R8 new high byte used after update");

      cyc();
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule